// File: doc/BRIEF.md
# Serial Character Transceiver Core

This block sends and receives asynchronous serial characters. A free-running oversampling strobe (`tick16`, sixteen strobes per bit time) paces both directions, and a 7-bit line-control word sets the character format. The format covers a word length of 5 to 8 bits, optional odd or even parity, one or two stop bits, a forced-low break output, and queue depth. Characters written on the transmit side wait in an internal queue and leave on `txd` least significant bit first. Characters arriving on `rxd` are recovered by centre sampling. Each one is stored, together with four error flags, in a receive queue that the host drains through a first-word-fall-through read port.

Host logic uses the block by setting `line_ctrl` while the line is idle and pushing bytes with `tx_wr`. It then reads `rx_data`/`rx_err` whenever `rx_empty` is low. The `loopback` input routes the transmitter's own line into the receiver, so a port can test itself without external wiring. Register decoding and baud-rate division belong to the surrounding logic.

Top module: `serial_line_core`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `tx_full` is 0 and `rx_empty` is 1.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then high stop bits; each bit lasts 16 `tick16` strobes. `line_ctrl[6:5]` gives the word length: 00 is 5, 01 is 6, 10 is 7, 11 is 8 bits; unused upper data bits are not sent.
- R3: With `line_ctrl[1]` set, a parity bit follows the data; `line_ctrl[2]`=1 makes the count of ones in data plus parity even, 0 makes it odd.
- R4: `line_ctrl[3]`=1 sends two stop bits, 0 sends one; the receiver checks only the first stop bit.
- R5: While `line_ctrl[0]` is set, `txd` is low from the next clock on, whatever the transmitter is doing.
- R6: `busy` is high while the transmit queue holds a character or a frame is in progress, and drops only after the last stop bit has completed.
- R7: A received character appears on `rx_data` right-aligned (upper unused bits 0). `rx_err` flags are framing at bit 0, parity at bit 1, break at bit 2 and overrun at bit 3; all are 0 for a clean character.
- R8: A parity bit that does not match sets `rx_err[1]`; a low first stop bit sets `rx_err[0]`.
- R9: A frame that is low from start bit through the stop position (data, parity if any, stop) stores one zero character with only `rx_err[2]` among the framing, parity and break flags set. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: A character that completes while the receive queue is full is dropped, and the next character stored carries `rx_err[3]`.
- R11: With `line_ctrl[4]`=0 each queue holds one character; with it set each holds `FIFO_DEPTH` characters. A write to a full queue is ignored.
- R12: With `loopback` high the receiver takes its input from `txd`, and the `rxd` pin has no effect.
- R13: A low pulse on the receive line that is gone by the eighth strobe after it started is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| line_ctrl | input | 7 | Format: [0] break, [1] parity on, [2] even parity, [3] two stops, [4] queues deep, [6:5] word length |
| loopback | input | 1 | Feed transmitter line into receiver |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Character to send |
| tx_full | output | 1 | Transmit queue cannot accept a write |
| busy | output | 1 | Transmitter has work queued or in flight |
| txd | output | 1 | Serial output line, idle high |
| rxd | input | 1 | Serial input line, idle high |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head character of the receive queue |
| rx_err | output | 4 | Head character flags: [0] framing, [1] parity, [2] break, [3] overrun |
| rx_empty | output | 1 | Receive queue holds nothing |

## Verification
A transmitter state or bit counter that goes wrong shows on `txd` within one bit time. It appears as a shifted, missing or extra bit in a frame, and the bench decodes every frame from the pin and does not rely on the round trip alone. A receiver fault shows within one frame: a mis-centred sampler, a lost parity or stop check, a missed break or an overrun that is not marked changes the data or flags at the head of the receive queue. A queue limit that is wrong shows as `tx_full` asserting too early or too late, or as a character that should have been dropped still arriving. A `busy` that falls early is caught by sampling it before and after the computed end of the last stop bit.

// File: rtl/serial_line_pkg.sv
package serial_line_pkg;

    localparam int WORD_MAX = 8;

    // Line-control word; member order matches the bit positions, LSB last.
    typedef struct packed {
        logic [1:0] wlen;      // [6:5]
        logic       deep_q;    // [4]
        logic       two_stop;  // [3]
        logic       even_par;  // [2]
        logic       par_en;    // [1]
        logic       brk;       // [0]
    } line_cfg_t;

    localparam int ERR_FRAME   = 0;
    localparam int ERR_PARITY  = 1;
    localparam int ERR_BREAK   = 2;
    localparam int ERR_OVERRUN = 3;
    localparam int ERR_W       = 4;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_e;

    // Index of the last data bit for a 2-bit word length code.
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
        return 3'(WORD_MAX - 4) + 3'(wlen);
    endfunction

    function automatic logic [WORD_MAX-1:0] word_mask(input logic [1:0] wlen);
        logic [WORD_MAX-1:0] m;
        for (int i = 0; i < WORD_MAX; i++) begin
            m[i] = (i <= int'(last_bit_idx(wlen)));
        end
        return m;
    endfunction

endpackage

// File: rtl/serial_char_queue.sv
module serial_char_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } q_regs_t;

    q_regs_t q_q, q_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (q_q.cnt == '0);
    assign full    = single ? (q_q.cnt != '0) : (q_q.cnt == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[q_q.rd];

    always_comb begin
        q_d = q_q;
        if (do_push) begin
            q_d.wr = (q_q.wr == PTR_LAST) ? '0 : q_q.wr + 1'b1;
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == PTR_LAST) ? '0 : q_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            q_d.cnt = q_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            q_d.cnt = q_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q_q.wr] <= din;
    end

    // A rejected write leaves the occupancy unchanged (R11).
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(q_q.cnt));

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNT_MAX);

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
    import serial_line_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                brk,
    input  logic                par_en,
    input  logic                even_par,
    input  logic                two_stop,
    input  logic [1:0]          wlen,
    input  logic                q_empty,
    input  logic [WORD_MAX-1:0] q_data,
    output logic                q_pop,
    output logic                txd,
    output logic                active
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        tx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [2:0]          idx;
        logic                extra_stop;
        logic [WORD_MAX-1:0] shreg;
        logic                txd;
    } tx_regs_t;

    localparam tx_regs_t TX_RST = '{st: TX_IDLE, cnt: '0, idx: '0,
                                   extra_stop: 1'b0, shreg: '0, txd: 1'b1};

    tx_regs_t q_q, q_d;
    logic bit_end;
    logic line_nxt;

    assign bit_end = tick && (q_q.cnt == LAST_TICK);
    assign txd     = q_q.txd;
    assign active  = (q_q.st != TX_IDLE);

    always_comb begin
        q_d   = q_q;
        q_pop = 1'b0;
        if (tick && q_q.st != TX_IDLE) begin
            q_d.cnt = bit_end ? '0 : q_q.cnt + 1'b1;
        end
        case (q_q.st)
            TX_IDLE: begin
                if (!q_empty) begin
                    q_pop     = 1'b1;
                    q_d.st    = TX_START;
                    q_d.cnt   = '0;
                    q_d.idx   = '0;
                    q_d.shreg = q_data & word_mask(wlen);
                end
            end
            TX_START: begin
                if (bit_end) q_d.st = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end) begin
                    if (q_q.idx == last_bit_idx(wlen)) begin
                        q_d.st         = par_en ? TX_PAR : TX_STOP;
                        q_d.extra_stop = two_stop;
                    end else begin
                        q_d.idx = q_q.idx + 1'b1;
                    end
                end
            end
            TX_PAR: begin
                if (bit_end) begin
                    q_d.st         = TX_STOP;
                    q_d.extra_stop = two_stop;
                end
            end
            TX_STOP: begin
                if (bit_end) begin
                    if (q_q.extra_stop) q_d.extra_stop = 1'b0;
                    else                q_d.st = TX_IDLE;
                end
            end
            default: q_d.st = TX_IDLE;
        endcase

        // The line level follows the state being entered, so both register together.
        case (q_d.st)
            TX_START: line_nxt = 1'b0;
            TX_DATA:  line_nxt = q_d.shreg[q_d.idx];
            TX_PAR:   line_nxt = (^q_d.shreg) ^ ~even_par;
            default:  line_nxt = 1'b1;
        endcase
        q_d.txd = brk ? 1'b0 : line_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= TX_RST;
        else        q_q <= q_d;
    end

    // Taking a character from the queue begins a low start bit (R2).
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !txd);

    // Break forces the line low on the following clock (R5).
    assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !txd);

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
    import serial_line_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                par_en,
    input  logic                even_par,
    input  logic [1:0]          wlen,
    input  logic                line,
    input  logic                q_full,
    output logic                push,
    output logic [WORD_MAX-1:0] pdata,
    output logic [ERR_W-1:0]    perr
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [2:0]          idx;
        logic [WORD_MAX-1:0] shreg;
        logic                par_line;
        logic                par_bad;
        logic                ovr_pend;
    } rx_regs_t;

    rx_regs_t q_q, q_d;
    logic at_centre;
    logic brk_seen;

    assign at_centre = tick && (q_q.cnt == LAST_TICK);
    assign brk_seen  = (q_q.shreg == '0) && !line && !q_q.par_line;

    always_comb begin
        q_d   = q_q;
        push  = 1'b0;
        pdata = q_q.shreg;
        perr  = '0;
        case (q_q.st)
            RX_IDLE: begin
                if (tick && !line) begin
                    q_d.st  = RX_START;
                    q_d.cnt = CNT_W'(1);
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q_q.cnt == MID_TICK) begin
                        if (line) begin
                            q_d.st = RX_IDLE;
                        end else begin
                            q_d.st       = RX_DATA;
                            q_d.cnt      = '0;
                            q_d.idx      = '0;
                            q_d.shreg    = '0;
                            q_d.par_line = 1'b0;
                            q_d.par_bad  = 1'b0;
                        end
                    end else begin
                        q_d.cnt = q_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (at_centre) begin
                    q_d.cnt            = '0;
                    q_d.shreg[q_q.idx] = line;
                    if (q_q.idx == last_bit_idx(wlen)) q_d.st = par_en ? RX_PAR : RX_STOP;
                    else                               q_d.idx = q_q.idx + 1'b1;
                end else if (tick) begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            RX_PAR: begin
                if (at_centre) begin
                    q_d.cnt      = '0;
                    q_d.par_line = line;
                    q_d.par_bad  = (line != ((^q_q.shreg) ^ ~even_par));
                    q_d.st       = RX_STOP;
                end else if (tick) begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (at_centre) begin
                    q_d.cnt = '0;
                    q_d.st  = line ? RX_IDLE : RX_HOLD;
                    if (q_full) begin
                        q_d.ovr_pend = 1'b1;
                    end else begin
                        push              = 1'b1;
                        perr[ERR_FRAME]   = !line && !brk_seen;
                        perr[ERR_PARITY]  = q_q.par_bad && !brk_seen;
                        perr[ERR_BREAK]   = brk_seen;
                        perr[ERR_OVERRUN] = q_q.ovr_pend;
                        q_d.ovr_pend      = 1'b0;
                    end
                end else if (tick) begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            RX_HOLD: begin
                if (line) q_d.st = RX_IDLE;
            end
            default: q_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // A break entry holds a zero character and no framing flag (R9).
    assert_break_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && perr[ERR_BREAK]) |-> (pdata == '0 && !perr[ERR_FRAME]));

    // Characters are never offered to a full queue (R10).
    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !q_full);

endmodule

// File: rtl/serial_line_core.sv
module serial_line_core
    import serial_line_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [6:0] line_ctrl,
    input  logic       loopback,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    output logic       tx_full,
    output logic       busy,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic [3:0] rx_err,
    output logic       rx_empty
);
    localparam int RXQ_W = ERR_W + WORD_MAX;

    line_cfg_t cfg;
    assign cfg = line_cfg_t'(line_ctrl);

    // Two-stage synchronizer on the receive input.
    logic [1:0] sync_q, sync_d;
    always_comb sync_d = {sync_q[0], loopback ? txd : rxd};
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= sync_d;
    end

    logic                txq_empty, tx_pop, tx_active;
    logic [WORD_MAX-1:0] txq_data;

    serial_char_queue #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .single(!cfg.deep_q),
        .push(tx_wr), .din(tx_data), .pop(tx_pop),
        .dout(txq_data), .empty(txq_empty), .full(tx_full)
    );

    serial_tx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .brk(cfg.brk), .par_en(cfg.par_en), .even_par(cfg.even_par),
        .two_stop(cfg.two_stop), .wlen(cfg.wlen),
        .q_empty(txq_empty), .q_data(txq_data), .q_pop(tx_pop),
        .txd(txd), .active(tx_active)
    );

    assign busy = tx_active || !txq_empty;

    logic                rx_push, rxq_full;
    logic [WORD_MAX-1:0] rx_pdata;
    logic [ERR_W-1:0]    rx_perr;

    serial_rx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .par_en(cfg.par_en), .even_par(cfg.even_par), .wlen(cfg.wlen),
        .line(sync_q[1]), .q_full(rxq_full),
        .push(rx_push), .pdata(rx_pdata), .perr(rx_perr)
    );

    serial_char_queue #(.WIDTH(RXQ_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .single(!cfg.deep_q),
        .push(rx_push), .din({rx_perr, rx_pdata}), .pop(rx_rd),
        .dout({rx_err, rx_data}), .empty(rx_empty), .full(rxq_full)
    );

    // When busy drops the queue is empty and the line is back at idle (R6).
    assert_idle_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (txq_empty && (txd || cfg.brk)));

endmodule

// File: tb/tb_serial_line_core.sv
module tb_serial_line_core;

    localparam int BIT_CYC = 32;   // tick16 every other clock, 16 strobes per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [6:0] lcr = 7'h70;
    logic       loopback = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic       tx_full, busy, txd, rx_empty;
    logic [7:0] rx_data;
    logic [3:0] rx_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    serial_line_core dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctrl(lcr),
        .loopback(loopback), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_full(tx_full), .busy(busy), .txd(txd), .rxd(rxd),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_err(rx_err), .rx_empty(rx_empty)
    );

    always #10 clk = ~clk;
    always @(posedge clk) tick16 <= ~tick16;

    typedef struct packed {
        logic [6:0] lc;
        logic [7:0] data;
    } vec_t;

    // 8N1, 7E1, 6O2, 5N2, 8O1, 5E1 (all with deep queues)
    localparam vec_t VECS [6] = '{
        '{7'h70, 8'hA5}, '{7'h56, 8'h5B}, '{7'h3A, 8'hFF},
        '{7'h18, 8'h13}, '{7'h72, 8'h80}, '{7'h16, 8'h0A}
    };

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [6:0] lc);
        return 5 + int'(lc[6:5]);
    endfunction

    function automatic logic [7:0] masked(input logic [6:0] lc, input logic [7:0] d);
        return d & 8'((9'd1 << nbits(lc)) - 9'd1);
    endfunction

    function automatic int flen(input logic [6:0] lc);
        return 1 + nbits(lc) + int'(lc[1]) + (lc[3] ? 2 : 1);
    endfunction

    function automatic logic fbit(input logic [6:0] lc, input logic [7:0] d, input int k);
        logic [7:0] m;
        int n;
        m = masked(lc, d);
        n = nbits(lc);
        if (k == 0) return 1'b0;
        if (k <= n) return m[k-1];
        if (lc[1] && k == n + 1) return (^m) ^ ~lc[2];
        return 1'b1;
    endfunction

    task automatic send_char(input logic [7:0] d);
        tx_data = d;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic check_tx_frame(input logic [6:0] lc, input logic [7:0] d, input string req);
        logic [15:0] act, exp;
        int guard;
        act = '0;
        exp = '0;
        guard = 0;
        while (txd !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT_CYC / 2) @(negedge clk);
        for (int k = 0; k < flen(lc); k++) begin
            act[k] = txd;
            exp[k] = fbit(lc, d, k);
            repeat (BIT_CYC) @(negedge clk);
        end
        check(act == exp, req, 32'(act), 32'(exp));
    endtask

    task automatic expect_rx(input logic [7:0] d, input logic [3:0] e, input string req);
        check(!rx_empty && rx_data == d && rx_err == e, req,
              {19'd0, rx_empty, rx_err, rx_data}, {19'd0, 1'b0, e, d});
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic drive_rx(input logic [6:0] lc, input logic [7:0] d,
                            input logic flip_par, input logic zero_stop);
        logic b;
        int n;
        n = nbits(lc);
        for (int k = 0; k < flen(lc); k++) begin
            b = fbit(lc, d, k);
            if (flip_par && lc[1] && k == n + 1) b = ~b;
            if (zero_stop && k == n + 1 + int'(lc[1])) b = 1'b0;
            rxd = b;
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(txd == 1'b1, "R1 txd idle", 32'(txd), 32'd1);
        check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
        check(tx_full == 1'b0, "R1 tx_full", 32'(tx_full), 32'd0);
        check(rx_empty == 1'b1, "R1 rx_empty", 32'(rx_empty), 32'd1);

        // Vector walk in loopback, rxd held low to show it is ignored.
        // R2 R3 R4 on the pin, R7 R12 at the receive port.
        loopback = 1'b1;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            lcr = VECS[i].lc;
            @(negedge clk);
            send_char(VECS[i].data);
            check_tx_frame(VECS[i].lc, VECS[i].data, "R2/R3/R4 frame on txd");
            repeat (4) @(negedge clk);
            expect_rx(masked(VECS[i].lc, VECS[i].data), 4'b0000, "R7/R12 loopback receive");
        end
        loopback = 1'b0;
        rxd = 1'b1;
        repeat (8) @(negedge clk);

        // R5: break forced by line_ctrl[0]
        lcr = 7'h71;
        @(negedge clk);
        check(txd == 1'b0, "R5 break asserted", 32'(txd), 32'd0);
        repeat (100) @(negedge clk);
        check(txd == 1'b0, "R5 break held", 32'(txd), 32'd0);
        lcr = 7'h70;
        @(negedge clk);
        check(txd == 1'b1, "R5 break released", 32'(txd), 32'd1);

        // R6: busy spans two queued 8N1 frames (about 645 cycles)
        send_char(8'h55);
        send_char(8'hC3);
        check(tx_full == 1'b0, "R11 deep queue accepts two", 32'(tx_full), 32'd0);
        repeat (598) @(negedge clk);
        check(busy == 1'b1, "R6 busy during last frame", 32'(busy), 32'd1);
        repeat (80) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R6 busy after last stop",
              {30'd0, busy, txd}, 32'd1);

        // R11: shallow transmit queue holds one character
        lcr = 7'h60;
        @(negedge clk);
        send_char(8'h01);
        @(negedge clk);
        send_char(8'h02);
        check(tx_full == 1'b1, "R11 shallow queue full", 32'(tx_full), 32'd1);
        wait_idle();
        repeat (8) @(negedge clk);

        // R13: short low glitch is not a start bit
        lcr = 7'h70;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        check(rx_empty == 1'b1, "R13 glitch rejected", 32'(rx_empty), 32'd1);

        // R8: parity error on 7E1
        lcr = 7'h56;
        @(negedge clk);
        drive_rx(7'h56, 8'h41, 1'b1, 1'b0);
        expect_rx(8'h41, 4'b0010, "R8 parity flag");

        // R8: framing error on 8N1
        lcr = 7'h70;
        @(negedge clk);
        drive_rx(7'h70, 8'h3C, 1'b0, 1'b1);
        expect_rx(8'h3C, 4'b0001, "R8 framing flag");

        // R9: break on 8E1, line low for twelve bit times
        lcr = 7'h76;
        @(negedge clk);
        rxd = 1'b0;
        repeat (12 * BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        expect_rx(8'h00, 4'b0100, "R9 break entry");
        check(rx_empty == 1'b1, "R9 single break entry", 32'(rx_empty), 32'd1);

        // R10 with R11: shallow receive queue overruns
        lcr = 7'h60;
        @(negedge clk);
        drive_rx(7'h60, 8'h11, 1'b0, 1'b0);
        drive_rx(7'h60, 8'h22, 1'b0, 1'b0);
        expect_rx(8'h11, 4'b0000, "R10 first kept");
        check(rx_empty == 1'b1, "R10 overrun char dropped", 32'(rx_empty), 32'd1);
        drive_rx(7'h60, 8'h33, 1'b0, 1'b0);
        expect_rx(8'h33, 4'b1000, "R10 overrun flag on next");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule